// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is an 8 KB data cache that sits between a CPU load/store port and a memory system. It holds 256 lines of 32 bytes each. Each byte address maps to exactly one line. Loads that find their line return data one cycle after acceptance. Loads that miss stall the CPU while the whole line is fetched as four 64-bit beats. After the fetch the held load is served from the freshly filled line.

Every store is passed on to an external write buffer. A store that hits also merges its enabled bytes into the cached word. A store that misses leaves the cache untouched. The CPU keeps a request steady for as long as the wait output is high. The request is taken on the first rising edge at which wait is low.

Top module: `dcache_wt`

## Requirements
- R1: The 34-bit byte address is decoded as tag = bits [33:13], set index = bits [12:5], word within line = bits [4:3] and byte lane = bits [2:0]. Only the tag and the set index choose the line; the word field picks one of the four 64-bit words.
- R2: After reset no line is valid, so the first load to any address causes a line fetch. While idle with no request, `cpuWait`, `fillReq`, `cpuRvalid` and `wbValid` are all low.
- R3: A load that hits sees `cpuWait` low in its request cycle. `cpuRvalid` is high in the next cycle, with `cpuRdata` equal to the addressed 64-bit word.
- R4: A load that misses keeps `cpuWait` high and raises `fillReq` with `fillAddr` = address bits [33:5]. `fillReq` stays high until four beats, marked by `memFillValid`, have been taken in word order 0, 1, 2, 3. The line then becomes valid with the new tag, and the held load completes as a hit.
- R5: A fill replaces whatever line occupied the indexed set. A later load of the displaced tag at that set misses again.
- R6: A store that hits writes only the byte lanes whose `cpuBe` bit is set (bit i covers data bits [8i+7:8i]) into the cached word. Later hits return the merged word.
- R7: A store that misses allocates nothing. The line already in that set still hits afterwards. A load of the stored address still misses and fetches the line from memory.
- R8: A store presented while `wbReady` is low keeps `cpuWait` high and completes only once `wbReady` is high.
- R9: Each accepted store, hit or miss, appears on the write port. In its acceptance cycle `wbValid` and `wbReady` are both high, and `wbAddr`, `wbData` and `wbBe` equal the CPU request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU request present |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 34 | Byte address |
| cpuWdata | input | 64 | Store data |
| cpuBe | input | 8 | Store byte enables |
| cpuWait | output | 1 | CPU must hold its request |
| cpuRvalid | output | 1 | Load data valid |
| cpuRdata | output | 64 | Load data |
| fillReq | output | 1 | Line fetch in progress |
| fillAddr | output | 29 | Line address being fetched |
| memFillValid | input | 1 | A fill beat is present |
| memFillData | input | 64 | Fill beat data |
| wbValid | output | 1 | Store offered to the write buffer |
| wbReady | input | 1 | Write buffer can accept |
| wbAddr | output | 34 | Store byte address |
| wbData | output | 64 | Store data |
| wbBe | output | 8 | Store byte enables |

## Verification
Faults in the cache's internal state show up at the ports in specific ways:

- A stale or wrongly written tag or valid bit shows at the ports at once. The next load to that set either raises `fillReq` when no fetch is due, or fails to raise it and returns a word that does not match memory.
- A beat stored into the wrong word slot stays hidden until a hit reads that slot. To catch it, every word of every set is read back right after its fill.
- A store that wrongly allocates, or that merges the wrong lanes, becomes visible on the first later load of that line or set.

The bench's reads are chosen so that each such fault is exposed within a few cycles.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  // Strobes from control to datapath, at most a few high in one cycle.
  typedef struct packed {
    logic rdAccept;   // load hit taken, capture data word
    logic wrHit;      // store hit taken, merge bytes
    logic fillStart;  // load miss, latch line address, drop valid
    logic fillBeat;   // one fill beat arrives
    logic fillDone;   // last fill beat, write tag and set valid
  } cacheStrobes_t;
endpackage

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 34,
  parameter int LINE_OFF_W = 5,
  parameter int INDEX_W    = 8,
  parameter int DATA_W     = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cacheStrobes_t                st,
  input  logic [ADDR_W-1:$clog2(DATA_W/8)] wordAddr,
  input  logic [DATA_W-1:0]            cpuWdata,
  input  logic [DATA_W/8-1:0]          cpuBe,
  input  logic [DATA_W-1:0]            memFillData,
  input  logic [LINE_OFF_W-$clog2(DATA_W/8)-1:0] beatCnt,
  output logic                         hit,
  output logic [DATA_W-1:0]            rdData,
  output logic [ADDR_W-LINE_OFF_W-1:0] fillAddr
);
  localparam int BYTE_W   = $clog2(DATA_W / 8);
  localparam int WSEL_W   = LINE_OFF_W - BYTE_W;
  localparam int TAG_W    = ADDR_W - LINE_OFF_W - INDEX_W;
  localparam int NSETS    = 1 << INDEX_W;
  localparam int WORDS    = 1 << WSEL_W;
  localparam int LINE_A_W = ADDR_W - LINE_OFF_W;
  localparam int LANES    = DATA_W / 8;

  logic [TAG_W-1:0]    tagMem  [NSETS];
  logic [DATA_W-1:0]   dataMem [NSETS*WORDS];
  logic [NSETS-1:0]    validBits;
  logic [LINE_A_W-1:0] fillLine;

  logic [TAG_W-1:0]   reqTag;
  logic [INDEX_W-1:0] reqIdx, fillIdx;
  logic [WSEL_W-1:0]  reqWord;
  logic [DATA_W-1:0]  laneMask;

  assign reqTag  = wordAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx  = wordAddr[LINE_OFF_W+INDEX_W-1:LINE_OFF_W];
  assign reqWord = wordAddr[LINE_OFF_W-1:BYTE_W];
  assign fillIdx = fillLine[INDEX_W-1:0];
  assign fillAddr = fillLine;

  // Expand byte enables into a bit mask, one lane per enable bit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneMask[8*g +: 8] = {8{cpuBe[g]}};
  end

  assign hit = validBits[reqIdx] && (tagMem[reqIdx] == reqTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      fillLine  <= '0;
    end else begin
      if (st.fillStart) begin
        validBits[reqIdx] <= 1'b0;
        fillLine          <= wordAddr[ADDR_W-1:LINE_OFF_W];
      end
      if (st.fillDone) validBits[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.fillDone) tagMem[fillIdx] <= fillLine[LINE_A_W-1:INDEX_W];
    if (st.fillBeat) dataMem[{fillIdx, beatCnt}] <= memFillData;
    if (st.wrHit)
      dataMem[{reqIdx, reqWord}] <= (dataMem[{reqIdx, reqWord}] & ~laneMask)
                                    | (cpuWdata & laneMask);
    if (st.rdAccept) rdData <= dataMem[{reqIdx, reqWord}];
  end

  // R4: the filled set is valid right after the last beat
  a_r4_valid_after_fill: assert property (@(posedge clk) disable iff (!rstN)
    st.fillDone |=> validBits[fillIdx]);
  // R7: stores and hits never change any valid bit
  a_r7_valid_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (!st.fillStart && !st.fillDone) |=> $stable(validBits));
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              hit,
  input  logic              wbReady,
  input  logic              memFillValid,
  output cacheStrobes_t     st,
  output logic [WSEL_W-1:0] beatCnt,
  output logic              cpuWait,
  output logic              cpuRvalid,
  output logic              fillReq,
  output logic              wbValid
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = '1;

  typedef enum logic {S_IDLE, S_FILL} ctrlState_t;
  ctrlState_t state;

  logic idle, rdReq, wrReq;
  assign idle  = (state == S_IDLE);
  assign rdReq = cpuReq && !cpuWe;
  assign wrReq = cpuReq && cpuWe;

  always_comb begin
    st           = '0;
    st.rdAccept  = idle && rdReq && hit;
    st.fillStart = idle && rdReq && !hit;
    st.wrHit     = idle && wrReq && wbReady && hit;
    st.fillBeat  = !idle && memFillValid;
    st.fillDone  = !idle && memFillValid && (beatCnt == LAST_BEAT);
  end

  assign cpuWait = idle ? ((rdReq && !hit) || (wrReq && !wbReady)) : cpuReq;
  assign fillReq = !idle;
  assign wbValid = idle && wrReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      beatCnt   <= '0;
      cpuRvalid <= 1'b0;
    end else begin
      cpuRvalid <= st.rdAccept;
      if (st.fillStart) begin
        state   <= S_FILL;
        beatCnt <= '0;
      end else if (st.fillBeat) begin
        beatCnt <= beatCnt + 1'b1;
        if (st.fillDone) state <= S_IDLE;
      end
    end
  end

  // R3: an accepted load returns data on the next cycle
  a_r3_hit_returns: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && !cpuWait) |=> cpuRvalid);
  // R4: a fetch cannot end without a beat
  a_r4_fill_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !memFillValid) |=> fillReq);
  // R8: a full write buffer stalls a store
  a_r8_store_stall: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && !wbReady) |-> cpuWait);
  // R9: an accepted store is handed to the write buffer in the same cycle
  a_r9_store_forward: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && !cpuWait) |-> (wbValid && wbReady));
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 34,
  parameter int LINE_OFF_W = 5,
  parameter int INDEX_W    = 8,
  parameter int DATA_W     = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         cpuWe,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [DATA_W-1:0]            cpuWdata,
  input  logic [DATA_W/8-1:0]          cpuBe,
  output logic                         cpuWait,
  output logic                         cpuRvalid,
  output logic [DATA_W-1:0]            cpuRdata,
  output logic                         fillReq,
  output logic [ADDR_W-LINE_OFF_W-1:0] fillAddr,
  input  logic                         memFillValid,
  input  logic [DATA_W-1:0]            memFillData,
  output logic                         wbValid,
  input  logic                         wbReady,
  output logic [ADDR_W-1:0]            wbAddr,
  output logic [DATA_W-1:0]            wbData,
  output logic [DATA_W/8-1:0]          wbBe
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = LINE_OFF_W - BYTE_W;

  cacheStrobes_t     st;
  logic              hit;
  logic [WSEL_W-1:0] beatCnt;

  assign wbAddr = cpuAddr;
  assign wbData = cpuWdata;
  assign wbBe   = cpuBe;

  dcache_ctrl #(.WSEL_W(WSEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .wbReady(wbReady), .memFillValid(memFillValid), .st(st),
    .beatCnt(beatCnt), .cpuWait(cpuWait), .cpuRvalid(cpuRvalid),
    .fillReq(fillReq), .wbValid(wbValid)
  );

  dcache_dp #(
    .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wordAddr(cpuAddr[ADDR_W-1:BYTE_W]),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .memFillData(memFillData),
    .beatCnt(beatCnt), .hit(hit), .rdData(cpuRdata), .fillAddr(fillAddr)
  );
endmodule

// File: tb/dcache_wt_tb.sv
module dcache_wt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [33:0] cpuAddr = '0;
  logic [63:0] cpuWdata = '0;
  logic [7:0]  cpuBe = '0;
  logic        cpuWait, cpuRvalid, fillReq, wbValid;
  logic [63:0] cpuRdata, wbData;
  logic [28:0] fillAddr;
  logic        memFillValid = 1'b0;
  logic [63:0] memFillData = '0;
  logic        wbReady = 1'b1;
  logic [33:0] wbAddr;
  logic [7:0]  wbBe;

  int checks = 0, fails = 0;
  logic [63:0] memModel [logic [30:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_wt u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuWait(cpuWait), .cpuRvalid(cpuRvalid),
    .cpuRdata(cpuRdata), .fillReq(fillReq), .fillAddr(fillAddr),
    .memFillValid(memFillValid), .memFillData(memFillData), .wbValid(wbValid),
    .wbReady(wbReady), .wbAddr(wbAddr), .wbData(wbData), .wbBe(wbBe)
  );

  function automatic logic [63:0] getWord(logic [30:0] wa);
    if (memModel.exists(wa)) return memModel[wa];
    return {1'b0, wa, 32'h5A0C_0000} ^ (64'(wa) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  function automatic logic [33:0] mkAddr(logic [20:0] t, logic [7:0] i,
                                         logic [1:0] w, logic [2:0] b);
    return {t, i, w, b};
  endfunction

  task automatic check(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Memory side: one beat every other cycle, in word order.
  initial begin
    int beat = 0, lat = 0;
    forever begin
      @(negedge clk);
      if (!fillReq) begin
        beat = 0; lat = 0; memFillValid = 1'b0;
      end else begin
        lat++;
        if (lat % 2 == 0 && beat < 4) begin
          memFillValid = 1'b1;
          memFillData  = getWord({fillAddr, 2'(beat)});
          beat++;
        end else memFillValid = 1'b0;
      end
    end
  end

  task automatic access(bit we, logic [33:0] a, logic [63:0] wd, logic [7:0] be,
                        bit expFill, string rq);
    bit sawFill = 0;
    logic [63:0] exp;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd; cpuBe = be;
    #1;
    while (cpuWait) begin
      @(negedge clk); #1;
      if (fillReq && !sawFill) begin
        sawFill = 1;
        check(fillAddr == a[33:5], "R4 fill address", 64'(fillAddr), 64'(a[33:5]));
      end
    end
    if (we) begin
      check(wbValid && wbReady && wbAddr == a && wbData == wd && wbBe == be,
            "R9 store on write port", wbData, wd);
      exp = getWord(a[33:3]);
      for (int k = 0; k < 8; k++) if (be[k]) exp[8*k +: 8] = wd[8*k +: 8];
      memModel[a[33:3]] = exp;
    end
    exp = getWord(a[33:3]);
    @(posedge clk); @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    #1;
    if (!we) check(cpuRvalid && cpuRdata == exp, {rq, " R3 load data"}, cpuRdata, exp);
    check(sawFill == expFill, {rq, " fetch presence"}, 64'(sawFill), 64'(expFill));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [20:0] tA = 21'h0ABCD, tB = 21'h1F00F, tC = 21'h00123;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R2: quiet after reset
    check(!cpuWait && !fillReq && !cpuRvalid && !wbValid, "R2 reset outputs",
          {60'd0, cpuWait, fillReq, cpuRvalid, wbValid}, 64'd0);

    // R1 R2 R4 R3: every set misses first, then all four words hit
    for (int i = 0; i < 256; i++) begin
      access(0, mkAddr(tA, 8'(i), 2'(i), 3'(i)), '0, '0, 1, "R2 R4 first load");
      for (int w = 0; w < 4; w++)
        access(0, mkAddr(tA, 8'(i), 2'(w), 3'(7 - w)), '0, '0, 0, "R1 R3 word hit");
    end

    // R5: conflicting tag replaces the line
    access(0, mkAddr(tB, 8'd5, 2'd1, 3'd0), '0, '0, 1, "R5 conflict miss");
    access(0, mkAddr(tB, 8'd5, 2'd3, 3'd0), '0, '0, 0, "R5 new line hits");
    access(0, mkAddr(tA, 8'd5, 2'd0, 3'd0), '0, '0, 1, "R5 old tag misses");

    // R6: byte-enable merge on store hits, each lane and full word
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 9; b++) begin
        logic [7:0]  be = (b < 8) ? 8'(1 << b) : 8'hFF;
        logic [63:0] wd = {8{8'(8'hA0 + b + 16 * w)}};
        access(1, mkAddr(tA, 8'd7, 2'(w), 3'd0), wd, be, 0, "R6 store hit");
        access(0, mkAddr(tA, 8'd7, 2'(w), 3'd0), '0, '0, 0, "R6 merged readback");
      end

    // R7: store miss does not allocate
    access(1, mkAddr(tC, 8'd9, 2'd2, 3'd0), 64'h0123_4567_89AB_CDEF, 8'h3C, 0, "R7 store miss");
    access(0, mkAddr(tA, 8'd9, 2'd2, 3'd0), '0, '0, 0, "R7 resident line kept");
    access(0, mkAddr(tC, 8'd9, 2'd2, 3'd0), '0, '0, 1, "R7 stored line fetched");
    access(0, mkAddr(tA, 8'd9, 2'd0, 3'd0), '0, '0, 1, "R7 displaced by fetch");

    // R8: store stalls while the write buffer is full
    wbReady = 1'b0;
    fork
      access(1, mkAddr(tA, 8'd11, 2'd1, 3'd0), 64'hFEED_FACE_DEAD_BEEF, 8'hF0, 0, "R8 stalled store");
      begin
        repeat (3) begin
          @(negedge clk); #2;
          check(cpuWait == 1'b1, "R8 wait while full", 64'(cpuWait), 64'd1);
        end
        wbReady = 1'b1;
      end
    join
    access(0, mkAddr(tA, 8'd11, 2'd1, 3'd0), '0, '0, 0, "R8 store landed once");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule